// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block gathers one-cycle event strobes from up to seven peripheral sources into a flag register. It masks them with an enable register and drives one active-high interrupt request. Each event sets its own flag. The flag stays set until software clears it by writing to the flag register, or until the surrounding peripheral pulses a dedicated clear strobe for that bit. The peripheral pulses a clear strobe as a side effect of certain register reads or writes of its own.

A byte-wide register port with a small address decodes two locations. The enable location uses a write protocol that modifies selected bits only: bit 7 of the written byte chooses whether the ones in bits 6..0 set or clear the matching enable bits. A read of the flag location returns a live summary bit in position 7, which is 1 while any enabled flag is pending. Software can therefore poll one byte instead of combining two.

Top module: `irqfe_top`

## Requirements
- R1: `irq_o` is a register. After each clock edge it equals the OR of (flag AND enable) as it stood before that edge, so it lags a flag or enable change by exactly one cycle.
- R2: A write to the enable address with data bit 7 = 1 sets each enable bit whose data bit (6..0) is 1 and leaves the others unchanged.
- R3: A write to the enable address with data bit 7 = 0 clears each enable bit whose data bit (6..0) is 1 and leaves the others unchanged.
- R4: Reading the enable address returns 1 in bit 7 and the enable bits in bits 6..0.
- R5: Reading the flag address returns the flags in bits 6..0, and in bit 7 a 1 exactly when (flag AND enable) is non-zero.
- R6: A write to the flag address clears each flag whose data bit (6..0) is 1 and never sets a flag.
- R7: While reset is held and after it is released, flags, enables and `irq_o` are all zero.
- R8: A pulse on `src_set_i[k]` sets flag k. The fixed bit positions are timer 1 = 6, timer 2 = 5, shift register = 2, and control lines = 0, 1, 3, 4.
- R9: A pulse on `src_clr_i[k]` clears flag k only.
- R10: When a set strobe coincides with a clear for the same flag, from a clear strobe or a flag write, the flag ends up set.
- R11: A write to any other address changes neither register, and a read of any other address returns 0. The default addresses are flag = 0xD and enable = 0xE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (4) | Register address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| src_set_i | input | 7 | Per-source event strobes that set flags |
| src_clr_i | input | 7 | Per-source clear strobes from the peripheral |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A flag or enable bit stuck, lost or wrongly set shows up on the very next read of either address. It also shows up on `irq_o` one cycle after the (flag AND enable) product first differs from the expected value. The bench reads back both locations and compares `irq_o` every cycle, so an error appears within a cycle of the fault. A wrong summary bit or a wrong latency is visible as a mismatch between `rdata_o[7]` and `irq_o`, or as `irq_o` moving one cycle early or late. Random mixes of coinciding set, clear and write traffic exercise the priority between set and clear.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
    localparam int DATA_W   = 8;
    localparam int NSRC     = DATA_W - 1;
    localparam int MODE_BIT = DATA_W - 1;

    localparam int SRC_CTRL0 = 0;
    localparam int SRC_CTRL1 = 1;
    localparam int SRC_SHIFT = 2;
    localparam int SRC_CTRL2 = 3;
    localparam int SRC_CTRL3 = 4;
    localparam int SRC_TMR2  = 5;
    localparam int SRC_TMR1  = 6;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t flag;
    } flag_state_t;

    typedef struct packed {
        src_vec_t en;
    } en_state_t;

    typedef struct packed {
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/irqfe_flag_bank.sv
module irqfe_flag_bank
    import irqfe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    input  src_vec_t wr_clr_i,
    output src_vec_t flag_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clearing first, then setting: a coinciding event is never lost
        st_d.flag = (st_q.flag & ~(clr_i | wr_clr_i)) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R10: every strobed flag is set on the following cycle
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));

    // R6: no flag rises without a set strobe
    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & ~($past(flag_o) | $past(set_i))) == '0));

    // R9: a cleared flag without a coinciding set is low afterwards
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|((clr_i | wr_clr_i) & ~set_i)) |=>
        ((flag_o & $past(clr_i | wr_clr_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irqfe_enable_bank.sv
module irqfe_enable_bank
    import irqfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output src_vec_t          en_o
);
    en_state_t st_d, st_q;
    logic      set_mode;
    src_vec_t  mask;

    assign set_mode = wdata_i[MODE_BIT];
    assign mask     = wdata_i[NSRC-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (set_mode) st_d.en = st_q.en | mask;
            else          st_d.en = st_q.en & ~mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    // R2: set-mode write raises the selected bits, keeps the rest
    a_r2_set_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && set_mode) |=>
        (en_o == ($past(en_o) | $past(mask))));

    // R3: clear-mode write drops the selected bits, keeps the rest
    a_r3_clear_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !set_mode) |=>
        (en_o == ($past(en_o) & ~$past(mask))));

    // R11: without a write the enables hold
    a_r11_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));
endmodule

// File: rtl/irqfe_irq_gen.sv
module irqfe_irq_gen
    import irqfe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t flag_i,
    input  src_vec_t en_i,
    output logic     pending_o,
    output logic     irq_o
);
    irq_state_t st_d, st_q;

    assign pending_o = |(flag_i & en_i);

    always_comb begin
        st_d     = st_q;
        st_d.irq = pending_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R1: request falls one cycle after the masked product empties
    a_r1_drop_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_i & en_i) == '0) |=> !irq_o);
endmodule

// File: rtl/irqfe_read_mux.sv
module irqfe_read_mux
    import irqfe_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 4'hE
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  src_vec_t          flag_i,
    input  src_vec_t          en_i,
    input  logic              pending_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (addr_i == FLAG_ADDR)    rdata_o = {pending_i, flag_i};
        else if (addr_i == EN_ADDR) rdata_o = {1'b1, en_i};
    end
endmodule

// File: rtl/irqfe_top.sv
module irqfe_top
    import irqfe_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 4'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic [6:0]        src_set_i,
    input  logic [6:0]        src_clr_i,
    output logic              irq_o
);
    logic     flag_wr, en_wr, pending;
    src_vec_t wr_clr, flag, en;

    assign flag_wr = wr_en_i && (addr_i == FLAG_ADDR);
    assign en_wr   = wr_en_i && (addr_i == EN_ADDR);
    assign wr_clr  = flag_wr ? wdata_i[NSRC-1:0] : '0;

    irqfe_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (src_set_i),
        .clr_i    (src_clr_i),
        .wr_clr_i (wr_clr),
        .flag_o   (flag)
    );

    irqfe_enable_bank u_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (wdata_i),
        .en_o    (en)
    );

    irqfe_irq_gen u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_i    (flag),
        .en_i      (en),
        .pending_o (pending),
        .irq_o     (irq_o)
    );

    irqfe_read_mux #(
        .ADDR_W    (ADDR_W),
        .FLAG_ADDR (FLAG_ADDR),
        .EN_ADDR   (EN_ADDR)
    ) u_rd (
        .addr_i    (addr_i),
        .flag_i    (flag),
        .en_i      (en),
        .pending_i (pending),
        .rdata_o   (rdata_o)
    );

    // R4: enable read always shows the marker bit
    a_r4_en_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == EN_ADDR) |-> rdata_o[7]);

    // R5: with flags and enables steady, the summary bit agrees with the request
    a_r5_summary_vs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == FLAG_ADDR && $stable(flag) && $stable(en)) |-> (rdata_o[7] == irq_o));

    // R7: nothing pending right after reset release
    a_r7_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (flag == '0 && en == '0 && !irq_o));
endmodule

// File: tb/irqfe_top_tb.sv
module irqfe_top_tb;
    localparam logic [3:0] FA = 4'hD;
    localparam logic [3:0] EA = 4'hE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [6:0] sset = '0;
    logic [6:0] sclr = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;

    logic [6:0] flag_m = '0;
    logic [6:0] en_m = '0;
    logic       irq_m = 1'b0;

    always #10 clk = ~clk;

    irqfe_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .wr_en_i   (wr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .src_set_i (sset),
        .src_clr_i (sclr),
        .irq_o     (irq)
    );

    function automatic logic [6:0] f_flag(logic [6:0] f, logic [6:0] s, logic [6:0] c,
                                          logic w, logic [3:0] a, logic [7:0] d);
        logic [6:0] wc;
        wc = (w && a == FA) ? d[6:0] : 7'h0;
        return (f & ~(c | wc)) | s;
    endfunction

    function automatic logic [6:0] f_en(logic [6:0] e, logic w, logic [3:0] a, logic [7:0] d);
        if (!(w && a == EA)) return e;
        return d[7] ? (e | d[6:0]) : (e & ~d[6:0]);
    endfunction

    function automatic logic [7:0] f_rd(logic [3:0] a);
        if (a == FA) return {|(flag_m & en_m), flag_m};
        if (a == EA) return {1'b1, en_m};
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] a, input logic w, input logic [7:0] d,
                         input logic [6:0] s, input logic [6:0] c);
        addr = a; wr = w; wdata = d; sset = s; sclr = c;
    endtask

    task automatic tick();
        @(posedge clk);
        irq_m  = |(flag_m & en_m);
        flag_m = f_flag(flag_m, sset, sclr, wr, addr, wdata);
        en_m   = f_en(en_m, wr, addr, wdata);
        @(negedge clk);
        drive(4'h0, 1'b0, 8'h00, '0, '0);
    endtask

    task automatic read_all(input string tag);
        addr = FA; #2 chk({tag, " flag read"}, rdata, f_rd(FA));
        addr = EA; #2 chk({tag, " enable read"}, rdata, f_rd(EA));
        addr = 4'h3; #2 chk({tag, " unmapped read"}, rdata, 8'h00);
        addr = 4'h0;
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, {7'h0, irq}, {7'h0, irq_m});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [3:0] ra;
        logic       rw;
        repeat (3) @(negedge clk);
        chk("R7 irq in reset", {7'h0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R7 after reset");
        chk_irq("R7 irq after reset");

        // R8: each source position sets its own flag
        for (int k = 0; k < 7; k++) begin
            drive(4'h0, 1'b0, 8'h00, 7'(1 << k), '0); tick();
            addr = FA; #2 chk($sformatf("R8 source %0d sets flag", k), rdata, f_rd(FA));
            drive(FA, 1'b1, 8'h7F, '0, '0); tick();
        end
        // timer 1 at bit 6 specifically
        drive(4'h0, 1'b0, 8'h00, 7'h40, '0); tick();
        addr = FA; #2 chk("R8 timer1 bit6", rdata, 8'h40);

        // R6: write of ones where flags are zero does not set
        drive(FA, 1'b1, 8'hBF, '0, '0); tick();
        addr = FA; #2 chk("R6 write never sets", rdata, 8'h40);
        drive(FA, 1'b1, 8'h40, '0, '0); tick();
        addr = FA; #2 chk("R6 write clears", rdata, 8'h00);

        // R2 / R4: set-mode enable write
        drive(EA, 1'b1, 8'h85, '0, '0); tick();
        addr = EA; #2 chk("R2 set mode R4 marker", rdata, 8'h85);
        drive(EA, 1'b1, 8'h82, '0, '0); tick();
        addr = EA; #2 chk("R2 keeps others", rdata, 8'h87);
        // R3: clear-mode enable write
        drive(EA, 1'b1, 8'h04, '0, '0); tick();
        addr = EA; #2 chk("R3 clear mode R4 marker", rdata, 8'h83);

        // R1 latency and R5 summary
        drive(4'h0, 1'b0, 8'h00, 7'h02, '0); tick();
        chk_irq("R1 not yet");
        chk("R1 one cycle early", {7'h0, irq}, 8'h00);
        addr = FA; #2 chk("R5 summary set", rdata, 8'h82);
        tick();
        chk("R1 raised after one cycle", {7'h0, irq}, 8'h01);
        drive(4'h0, 1'b0, 8'h00, 7'h10, '0); tick(); tick();
        drive(EA, 1'b1, 8'h02, '0, '0); tick(); tick();
        addr = FA; #2 chk("R5 summary masked", rdata, 8'h12);
        chk("R1 dropped when masked", {7'h0, irq}, 8'h00);

        // R9: clear strobe hits only its bit
        drive(4'h0, 1'b0, 8'h00, '0, 7'h10); tick();
        addr = FA; #2 chk("R9 strobe clears one", rdata, 8'h02);

        // R10: set beats clear strobe and flag write
        drive(4'h0, 1'b0, 8'h00, 7'h20, 7'h20); tick();
        addr = FA; #2 chk("R10 set beats strobe", rdata, 8'h22);
        drive(FA, 1'b1, 8'h7F, 7'h04, '0); tick();
        addr = FA; #2 chk("R10 set beats write", rdata, 8'h04);

        // R11: write elsewhere is ignored
        drive(4'h5, 1'b1, 8'hFF, '0, '0); tick();
        read_all("R11 other address");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            case ($urandom_range(0, 2))
                0: ra = FA;
                1: ra = EA;
                default: ra = 4'($urandom_range(0, 12));
            endcase
            rw = ($urandom_range(0, 2) != 0);
            drive(ra, rw, 8'($urandom), 7'($urandom & $urandom),
                  7'($urandom & $urandom & $urandom));
            tick();
            chk_irq("R1 random irq");
            read_all("R5 R4 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : seed
        int unused_seed;
        unused_seed = $urandom(32'h1F2E3D4C);
    end
endmodule